// File: doc/BRIEF.md
# Byte-Banked Memory Access Unit

This unit connects a 32-bit load/store port to a memory built from four byte-wide banks. Each bank holds one byte lane of every 32-bit row. A request gives a byte address, an access size, a read or write flag, a sign/zero choice for loads and write data. The unit works out which banks the access touches and moves each byte between its register lane and its bank lane. Loads come back right-justified in the result.

An access that fits inside one row uses a single bank cycle. A word at a byte offset other than zero, or a halfword at offset 3, crosses into the next row. The unit then runs two bank cycles, the first on the lower row and the second on the row above, and merges the two halves. A static input selects big-endian or little-endian byte ordering. The banks are modelled as single-cycle synchronous RAMs: read data appears on the cycle after the bank cycle that requested it.

Top module: `bank_access_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `done`, `bankEn` and `bankWe` are all zero.
- R2: An access that stays inside one row (any byte, a halfword at offset 0 to 2, a word at offset 0) uses exactly one bank cycle. `done` rises two clock edges after the edge that accepted the request.
- R3: An access that crosses a row uses two bank cycles. The first addresses row `addr>>2` and the second addresses that row plus one, modulo the row count. `done` rises three edges after acceptance.
- R4: `busy` is high on every bank cycle of an access, including the second cycle of a split, and low otherwise. A request is accepted only while `busy` is low.
- R5: `done` is a single-cycle pulse, one per accepted request, for reads and writes alike.
- R6: In each bank cycle, `bankEn` has a bit set only for banks holding bytes of the access in that row. `bankWe` equals `bankEn` on writes and is zero on reads, so bytes outside the access are never changed.
- R7: Bank lane b is `bankWdata`/`bankRdata` bits [8b+7:8b] and holds the byte whose address has low bits equal to b.
- R8: With `bigEndian` low, value byte i (i=0 least significant) sits at address A+i. With `bigEndian` high, it sits at address A+N-1-i, where N is the access size in bytes.
- R9: Byte and halfword loads return the value in the low bits of `rdData`. The upper bits copy the value's top bit when `reqSigned` is high and are zero otherwise.
- R10: `reqSize` encodes 00 as a byte, 01 as a halfword, 10 as a word, and 11 is handled as a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; taken when busy is low |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 00 byte, 01 halfword, 10/11 word |
| reqSigned | input | 1 | Sign-extend sub-word loads |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 32 | Store value, right-justified |
| bigEndian | input | 1 | Byte ordering select |
| busy | output | 1 | Bank cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Load result, valid while done is high |
| bankRow | output | ADDR_W-2 | Row address shared by all banks |
| bankEn | output | 4 | Per-bank access enable |
| bankWe | output | 4 | Per-bank write enable |
| bankWdata | output | 32 | Bank write data, lane b = bits [8b+7:8b] |
| bankRdata | input | 32 | Bank read data, one cycle after enable |

## Verification
The bench sweeps every size, byte offset and byte ordering, for stores and for signed and unsigned loads. After each store it compares the whole memory with a reference. A unit that enabled a stray write lane would corrupt a neighbouring byte. One that mirrored the ordering wrongly would put a reversed value in memory. Row-crossing cases include a word at the highest row. A design that failed to wrap the row, or that issued only one cycle, would return stale bytes in the upper half or finish one cycle early. Sign-bit-set bytes loaded with and without extension catch a unit that extended from the wrong bit or ignored the flag.

// File: rtl/bau_pkg.sv
package bau_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int OFF_W  = $clog2(LANES);

  typedef struct packed {
    logic accept;   // capture a new request
    logic issue;    // a bank cycle is driven this cycle
    logic second;   // this bank cycle is the upper-row half
    logic capture;  // hold the read bytes of the lower-row half
    logic finish;   // merged result / completion visible
  } ctrl_strobe_t;
endpackage

// File: rtl/bau_ctrl.sv
module bau_ctrl
  import bau_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         needSplit,
  output ctrl_strobe_t strobe,
  output logic         busy,
  output logic         done
);
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND, ST_DONE} state_e;
  state_e state, stateNext;
  logic   canAccept;

  assign canAccept = (state == ST_IDLE) || (state == ST_DONE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_FIRST;
      ST_FIRST:  stateNext = needSplit ? ST_SECOND : ST_DONE;
      ST_SECOND: stateNext = ST_DONE;
      ST_DONE:   stateNext = reqValid ? ST_FIRST : ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    strobe.accept  = reqValid && canAccept;
    strobe.issue   = (state == ST_FIRST) || (state == ST_SECOND);
    strobe.second  = (state == ST_SECOND);
    strobe.capture = (state == ST_SECOND);
    strobe.finish  = (state == ST_DONE);
  end

  assign busy = strobe.issue;
  assign done = strobe.finish;
endmodule

// File: rtl/bau_datapath.sv
module bau_datapath
  import bau_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int ROW_W = ADDR_W - OFF_W
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrl_strobe_t             strobe,
  input  logic                     reqWrite,
  input  logic [1:0]               reqSize,
  input  logic                     reqSigned,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [WORD_W-1:0]        reqWdata,
  input  logic                     bigEndian,
  input  logic [WORD_W-1:0]        bankRdata,
  output logic                     needSplit,
  output logic [ROW_W-1:0]         bankRow,
  output logic [LANES-1:0]         bankEn,
  output logic [LANES-1:0]         bankWe,
  output logic [WORD_W-1:0]        bankWdata,
  output logic [WORD_W-1:0]        rdData
);
  localparam int CNT_W = OFF_W + 1;
  localparam int POS_W = OFF_W + 2;

  // captured request
  logic              aWrite, aSigned, aBig;
  logic [CNT_W-1:0]  aCount;
  logic [OFF_W-1:0]  aOff;
  logic [ROW_W-1:0]  aRow;
  logic [WORD_W-1:0] aWdata;
  logic [CNT_W-1:0]  reqCount;

  always_comb begin
    unique case (reqSize)
      2'b00:   reqCount = CNT_W'(1);
      2'b01:   reqCount = CNT_W'(2);
      default: reqCount = CNT_W'(LANES);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aWrite  <= 1'b0;
      aSigned <= 1'b0;
      aBig    <= 1'b0;
      aCount  <= CNT_W'(1);
      aOff    <= '0;
      aRow    <= '0;
      aWdata  <= '0;
    end else if (strobe.accept) begin
      aWrite  <= reqWrite;
      aSigned <= reqSigned;
      aBig    <= bigEndian;
      aCount  <= reqCount;
      aOff    <= reqAddr[OFF_W-1:0];
      aRow    <= reqAddr[ADDR_W-1:OFF_W];
      aWdata  <= reqWdata;
    end
  end

  assign needSplit = (POS_W'(aOff) + POS_W'(aCount)) > POS_W'(LANES);
  assign bankRow   = aRow + ROW_W'(strobe.second);

  // per-lane steering
  logic [LANES-1:0]            laneHit;
  logic [LANES-1:0][OFF_W-1:0] laneIdx;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [POS_W-1:0] lanePos;
    logic [CNT_W-1:0] revPos;

    assign lanePos = POS_W'(b) + (strobe.second ? POS_W'(LANES) : POS_W'(0)) - POS_W'(aOff);
    assign revPos  = aCount - CNT_W'(1) - lanePos[CNT_W-1:0];

    assign laneHit[b] = strobe.issue && (lanePos < POS_W'(aCount));
    assign laneIdx[b] = aBig ? revPos[OFF_W-1:0] : lanePos[OFF_W-1:0];

    assign bankEn[b] = laneHit[b];
    assign bankWe[b] = laneHit[b] && aWrite;
    assign bankWdata[b*LANE_W +: LANE_W] = aWdata[laneIdx[b]*LANE_W +: LANE_W];
  end

  // read gathering
  logic [LANES-1:0]            prevHit;
  logic [LANES-1:0][OFF_W-1:0] prevIdx;
  logic [WORD_W-1:0]           gather;
  logic [WORD_W-1:0]           merged;
  logic [WORD_W-1:0]           extended;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevHit <= '0;
      prevIdx <= '0;
    end else if (strobe.issue) begin
      prevHit <= laneHit;
      prevIdx <= laneIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.accept) begin
      gather <= '0;
    end else if (strobe.capture) begin
      for (int b = 0; b < LANES; b++) begin
        if (prevHit[b]) gather[prevIdx[b]*LANE_W +: LANE_W] <= bankRdata[b*LANE_W +: LANE_W];
      end
    end
  end

  always_comb begin
    merged = gather;
    for (int b = 0; b < LANES; b++) begin
      if (prevHit[b]) merged[prevIdx[b]*LANE_W +: LANE_W] = bankRdata[b*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    unique case (aCount)
      CNT_W'(1): extended = {{(WORD_W-LANE_W){aSigned & merged[LANE_W-1]}},
                             merged[LANE_W-1:0]};
      CNT_W'(2): extended = {{(WORD_W-2*LANE_W){aSigned & merged[2*LANE_W-1]}},
                             merged[2*LANE_W-1:0]};
      default:   extended = merged;
    endcase
  end

  assign rdData = strobe.finish ? extended : '0;
endmodule

// File: rtl/bank_access_unit.sv
module bank_access_unit
  import bau_pkg::*;
#(
  parameter int ADDR_W = 8
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [1:0]           reqSize,
  input  logic                 reqSigned,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [31:0]          reqWdata,
  input  logic                 bigEndian,
  output logic                 busy,
  output logic                 done,
  output logic [31:0]          rdData,
  output logic [ADDR_W-3:0]    bankRow,
  output logic [3:0]           bankEn,
  output logic [3:0]           bankWe,
  output logic [31:0]          bankWdata,
  input  logic [31:0]          bankRdata
);
  localparam int ROW_W = ADDR_W - OFF_W;

  ctrl_strobe_t strobe;
  logic         needSplit;

  bau_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .needSplit (needSplit),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  bau_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .reqWrite  (reqWrite),
    .reqSize   (reqSize),
    .reqSigned (reqSigned),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .bigEndian (bigEndian),
    .bankRdata (bankRdata),
    .needSplit (needSplit),
    .bankRow   (bankRow),
    .bankEn    (bankEn),
    .bankWe    (bankWe),
    .bankWdata (bankWdata),
    .rdData    (rdData)
  );
endmodule

// File: rtl/bau_checker.sv
module bau_checker #(
  parameter int ROW_W = 6
)(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [3:0]       bankEn,
  input logic [3:0]       bankWe,
  input logic [ROW_W-1:0] bankRow
);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_follows_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  p_busy_done_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_we_within_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bankWe & ~bankEn) == 4'b0000);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bankEn == 4'b0000));

  p_upper_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (bankRow == ROW_W'($past(bankRow) + 1'b1)));
endmodule

bind bank_access_unit bau_checker #(.ROW_W(ROW_W)) u_bau_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .bankEn  (bankEn),
  .bankWe  (bankWe),
  .bankRow (bankRow)
);

// File: tb/test_bank_access_unit.sv
module test_bank_access_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int MEM_BYTES  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reqValid = 1'b0, reqWrite = 1'b0, reqSigned = 1'b0, bigEndian = 1'b0;
  logic [1:0]        reqSize = 2'b00;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0]       reqWdata = '0;
  logic              busy, done;
  logic [31:0]       rdData, bankWdata;
  logic [31:0]       bankRdata = '0;
  logic [ADDR_W-3:0] bankRow;
  logic [3:0]        bankEn, bankWe;

  logic [7:0] mem    [MEM_BYTES];
  logic [7:0] refMem [MEM_BYTES];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_access_unit #(.ADDR_W(ADDR_W)) i_bank_access_unit (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqSigned(reqSigned), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .bigEndian(bigEndian), .busy(busy), .done(done),
    .rdData(rdData), .bankRow(bankRow), .bankEn(bankEn), .bankWe(bankWe),
    .bankWdata(bankWdata), .bankRdata(bankRdata)
  );

  // synchronous byte-lane RAM model
  always @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      if (bankEn[b]) begin
        if (bankWe[b]) mem[{bankRow, 2'(b)}] <= bankWdata[b*8 +: 8];
        bankRdata[b*8 +: 8] <= mem[{bankRow, 2'(b)}];
      end
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sizeBytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [7:0] byteAddr(input logic [7:0] a, input int n, input int j, input logic big);
    return big ? 8'(a + 8'(n - 1 - j)) : 8'(a + 8'(j));
  endfunction

  task automatic access(input logic w, input logic [1:0] sz, input logic sgn, input logic big,
                        input logic [7:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat, output int busyCnt,
                        output logic doneAfter);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqSize = sz; reqSigned = sgn;
    bigEndian = big; reqAddr = addr; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    busyCnt = busy ? 1 : 0;
    while (!done && lat < 12) begin
      @(negedge clk);
      lat++;
      if (busy) busyCnt++;
    end
    rd = rdData;
    @(negedge clk);
    doneAfter = done;
  endtask

  task automatic doWrite(input logic [1:0] sz, input logic big, input logic [7:0] addr, input logic [31:0] wd);
    logic [31:0] rd; int lat, bc; logic da; int n, expLat, bad;
    n = sizeBytes(sz);
    expLat = (int'(addr[1:0]) + n > 4) ? 3 : 2;
    for (int j = 0; j < n; j++) refMem[byteAddr(addr, n, j, big)] = wd[8*j +: 8];
    access(1'b1, sz, 1'b0, big, addr, wd, rd, lat, bc, da);
    check(lat == expLat, (expLat == 3) ? "R3 split write latency" : "R2 single write latency", 32'(lat), 32'(expLat));
    check(bc == expLat - 1, "R4 busy cycles on write", 32'(bc), 32'(expLat - 1));
    check(!da, "R5 done pulse width", 32'(da), 32'd0);
    bad = 0;
    for (int i = 0; i < MEM_BYTES; i++) if (mem[i] !== refMem[i]) bad++;
    check(bad == 0, "R6 R7 R8 memory image after write", 32'(bad), 32'd0);
  endtask

  task automatic doRead(input logic [1:0] sz, input logic sgn, input logic big, input logic [7:0] addr, input string tag);
    logic [31:0] rd, exp; int lat, bc; logic da; int n, expLat;
    n = sizeBytes(sz);
    expLat = (int'(addr[1:0]) + n > 4) ? 3 : 2;
    exp = '0;
    for (int j = 0; j < n; j++) exp[8*j +: 8] = refMem[byteAddr(addr, n, j, big)];
    if (sgn && n < 4 && exp[8*n-1]) for (int k = 8*n; k < 32; k++) exp[k] = 1'b1;
    access(1'b0, sz, sgn, big, addr, 32'h0, rd, lat, bc, da);
    check(rd == exp, tag, rd, exp);
    check(lat == expLat, (expLat == 3) ? "R3 split read latency" : "R2 single read latency", 32'(lat), 32'(expLat));
    check(bc == expLat - 1, "R4 busy cycles on read", 32'(bc), 32'(expLat - 1));
    check(!da, "R5 done pulse width on read", 32'(da), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    for (int i = 0; i < MEM_BYTES; i++) begin
      mem[i]    = 8'(i * 37 + 11);
      refMem[i] = 8'(i * 37 + 11);
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && bankEn == 4'b0 && bankWe == 4'b0, "R1 idle during reset",
          {24'd0, busy, done, bankEn, 2'b0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && bankEn == 4'b0, "R1 idle after reset", {27'd0, busy, done, bankEn[0], 2'b0}, 32'd0);

    // write sweep: every ordering, size and offset
    for (int big = 0; big < 2; big++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++)
          doWrite(2'(sz), 1'(big), 8'(big*96 + sz*24 + off + 8), 32'hA1B2C3D4 ^ 32'(big*7 + sz*131 + off*4099));

    // read sweep, including signed and unsigned
    for (int big = 0; big < 2; big++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++)
          for (int sgn = 0; sgn < 2; sgn++)
            doRead(2'(sz), 1'(sgn), 1'(big), 8'(8'h80 + big*40 + sz*8 + off),
                   "R8 R9 read value sweep");

    // reads leave memory untouched
    bad = 0;
    for (int i = 0; i < MEM_BYTES; i++) if (mem[i] !== refMem[i]) bad++;
    check(bad == 0, "R6 reads write nothing", 32'(bad), 32'd0);

    // sign extension boundaries
    doWrite(2'b00, 1'b0, 8'h21, 32'h000000F0);
    doRead(2'b00, 1'b1, 1'b0, 8'h21, "R9 signed byte extension");
    doRead(2'b00, 1'b0, 1'b0, 8'h21, "R9 unsigned byte zero fill");
    doWrite(2'b01, 1'b1, 8'h33, 32'h00008A05);
    doRead(2'b01, 1'b1, 1'b1, 8'h33, "R9 signed split halfword big-endian");
    doRead(2'b01, 1'b1, 1'b0, 8'h33, "R8 halfword read back in other ordering");

    // row wrap at the top of the address space
    doWrite(2'b10, 1'b0, 8'hFE, 32'h11223344);
    check(mem[8'h00] == 8'h22 && mem[8'h01] == 8'h11, "R3 upper half lands in row 0",
          {16'd0, mem[8'h01], mem[8'h00]}, 32'h00001122);
    doRead(2'b10, 1'b0, 1'b1, 8'hFD, "R3 R7 wrapped word big-endian");

    // size code 11 behaves as a word
    doRead(2'b11, 1'b1, 1'b0, 8'h44, "R10 size 11 acts as word");
    doRead(2'b11, 1'b0, 1'b1, 8'h46, "R10 size 11 split word");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule